// File: doc/BRIEF.md
# Full-Frame CCD Readout Sequencer

This block is the timing engine behind a two-phase full-frame CCD sensor. On a start request it opens an exposure window. While that window is open both vertical phases stay low. The window closes after a programmed number of clocks, or earlier when an external done signal arrives. The block then reads the whole sensor out one row at a time. For each row it first runs the vertical phases through a four-step transfer, which ends with vertical phase 2 falling while horizontal phase 1 is high. It then shifts the horizontal register one pixel at a time.

Within each pixel period the block does four things in a fixed order. It pulses the reset gate, waits a settle interval, and strobes the reset-level sample. It then drops horizontal phase 2, which moves the next charge packet onto the sense node, and finally strobes the signal-level sample. Every signal-level strobe carries a column index, a row index and a pixel class, so that downstream logic can separate out the dummy and shielded reference pixels.

Each line is framed by 10 dummy and 4 dark pixels in front and by 12 dark and 2 dummy pixels behind. Each frame is framed by 4 dark rows at the top and 4 at the bottom. The frame ends with a one-cycle done flag, and the phases then return to their idle levels.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset, and whenever the block is idle, the outputs are `vphase1`=0, `vphase2`=0, `hphase1`=1, `hphase2`=0, `rst_gate`=0, `samp_ref`=0, `samp_sig`=0, `exposing`=0 and `frame_done`=0.
- R2: A high `expose_start` in an idle cycle raises `exposing` from the next cycle. `exposing` then stays high for exactly `int_time` cycles, where a value of 0 counts as 1. A high `expose_done` during an exposing cycle makes that cycle the last one. Both vertical phases stay low while `exposing` is high.
- R3: Readout never overlaps the exposure. In the first cycle after the last exposing cycle, `vphase1` is high and `vphase2` is low.
- R4: Each row starts with a transfer of four steps, each lasting T_V cycles, in this order: `vphase1` alone, both vertical phases high, `vphase2` alone, both low. `vphase2` therefore falls 3*T_V cycles after `vphase1` rises. Throughout the transfer `hphase1`=1 and `hphase2`=0. A frame has ACT_ROWS+8 such transfers.
- R5: `hphase1` and `hphase2` are complementary in every cycle. During row readout `hphase2` falls exactly ACT_COLS+28 times per row.
- R6: A pixel period is T_RG+T_SET+T_XF+2 cycles long. It consists of `rst_gate` high for T_RG cycles, T_SET settle cycles, one `samp_ref` cycle, the `hphase2` fall followed by T_XF cycles, and then one `samp_sig` cycle. The `samp_sig` cycle comes T_XF cycles after the fall.
- R7: During `samp_sig`, `pix_col` holds the pixel's position in the line (0 at the first pixel shifted out) and `pix_row` holds the row's position in the frame (0 at the first row).
- R8: `pix_kind` encodes 0 = dummy, 1 = dark and 2 = active. Along a line, columns 0..9 are dummy, 10..13 are dark, the next ACT_COLS are active, the next 12 are dark and the last 2 are dummy.
- R9: In rows 0..3 and in the last 4 rows, every column that is not dummy is reported as dark. Dummy columns stay dummy in every row.
- R10: `frame_done` is high for exactly one cycle. That cycle comes (exposure length) + (ACT_ROWS+8)*(4*T_V + (ACT_COLS+28)*(T_RG+T_SET+T_XF+2)) cycles after the first exposing cycle. In the next cycle all outputs are at their idle levels.
- R11: `expose_start` has no effect outside idle. A request made during readout changes neither the frame timing nor the state afterwards, and no exposure follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| expose_start | input | 1 | Begin an exposure (honoured only when idle) |
| expose_done | input | 1 | End the exposure early |
| int_time | input | INT_W | Exposure length in clocks |
| vphase1 | output | 1 | Vertical phase 1 |
| vphase2 | output | 1 | Vertical phase 2 |
| hphase1 | output | 1 | Horizontal phase 1 |
| hphase2 | output | 1 | Horizontal phase 2 |
| rst_gate | output | 1 | Sense-node reset pulse |
| samp_ref | output | 1 | Reset-level sample strobe |
| samp_sig | output | 1 | Signal-level sample strobe |
| exposing | output | 1 | Exposure window open |
| frame_done | output | 1 | One-cycle end-of-frame flag |
| pix_col | output | COL_W | Column tag of the current pixel |
| pix_row | output | ROW_W | Row tag of the current pixel |
| pix_kind | output | 2 | Pixel class: 0 dummy, 1 dark, 2 active |

## Verification
All outputs are registered on the same edge that updates the sequencer state. A start request sampled at one edge therefore shows up as `exposing` in the very next cycle, and `frame_done` appears exactly the R10 interval after the first exposing cycle. The bench samples every output on the falling clock edge and timestamps each event (exposure edges, vertical phase rise and fall, `hphase2` fall, reset pulse, sample strobes) with a cycle counter. It then compares the gaps between events with the intervals that R4, R6 and R10 give in closed form, so it never guesses at an absolute cycle. The pixel tags are checked against a column and row count that the bench keeps itself from the `hphase2` falls and the line-load edges.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    PK_DUMMY  = 2'd0,
    PK_DARK   = 2'd1,
    PK_ACTIVE = 2'd2
  } pix_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_INTEG,
    S_VA, S_VB, S_VC, S_VD,
    S_RG, S_SET, S_SHP, S_XF, S_SHD,
    S_DONE
  } seq_st_t;

endpackage

// File: rtl/ccd_int_timer.sv
module ccd_int_timer #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [INT_W-1:0] len,
  input  logic             stop_req,
  output logic             expired
);

  logic [INT_W-1:0] cnt;
  logic [INT_W:0]   cnt_p1;

  assign cnt_p1  = {1'b0, cnt} + (INT_W+1)'(1);
  assign expired = run && (stop_req || (cnt_p1 >= {1'b0, len}));

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (run && (cnt != '1))
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ccd_pix_class.sv
module ccd_pix_class
  import ccd_seq_pkg::*;
#(
  parameter int ACT_COLS   = 64,
  parameter int ACT_ROWS   = 48,
  parameter int LEAD_DUM   = 10,
  parameter int LEAD_DARK  = 4,
  parameter int TRAIL_DARK = 12,
  parameter int TOP_ROWS   = 4,
  parameter int BOT_ROWS   = 4,
  parameter int COL_W      = 7,
  parameter int ROW_W      = 6
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  output pix_kind_t        kind
);

  localparam logic [COL_W-1:0] C_DARK_BEG = COL_W'(LEAD_DUM);
  localparam logic [COL_W-1:0] C_ACT_BEG  = COL_W'(LEAD_DUM + LEAD_DARK);
  localparam logic [COL_W-1:0] C_ACT_END  = COL_W'(LEAD_DUM + LEAD_DARK + ACT_COLS);
  localparam logic [COL_W-1:0] C_DUM_BEG  = COL_W'(LEAD_DUM + LEAD_DARK + ACT_COLS + TRAIL_DARK);
  localparam logic [ROW_W-1:0] R_ACT_BEG  = ROW_W'(TOP_ROWS);
  localparam logic [ROW_W-1:0] R_ACT_END  = ROW_W'(TOP_ROWS + ACT_ROWS);

  // BOT_ROWS only sizes the frame at the top level; rows past R_ACT_END are dark.
  logic col_dummy, col_dark, row_dark;

  assign col_dummy = (col < C_DARK_BEG) || (col >= C_DUM_BEG);
  assign col_dark  = (col < C_ACT_BEG)  || (col >= C_ACT_END);
  assign row_dark  = (row < R_ACT_BEG)  || (row >= R_ACT_END);

  always_comb begin
    if (col_dummy)                kind = PK_DUMMY;
    else if (col_dark || row_dark) kind = PK_DARK;
    else                          kind = PK_ACTIVE;
  end

endmodule

// File: rtl/ccd_seq_core.sv
module ccd_seq_core
  import ccd_seq_pkg::*;
#(
  parameter int LINE_PIX = 92,
  parameter int ROWS     = 56,
  parameter int T_V      = 4,
  parameter int T_RG     = 2,
  parameter int T_SET    = 2,
  parameter int T_XF     = 2,
  parameter int STEP_W   = 8,
  parameter int COL_W    = 7,
  parameter int ROW_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             int_end,
  output seq_st_t          st,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             v1,
  output logic             v2,
  output logic             h1,
  output logic             h2,
  output logic             rg,
  output logic             shp,
  output logic             shd,
  output logic             expo,
  output logic             done
);

  localparam logic [COL_W-1:0]  COL_LAST = COL_W'(LINE_PIX - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [STEP_W-1:0] D_V      = STEP_W'(T_V - 1);
  localparam logic [STEP_W-1:0] D_RG     = STEP_W'(T_RG - 1);
  localparam logic [STEP_W-1:0] D_SET    = STEP_W'(T_SET - 1);
  localparam logic [STEP_W-1:0] D_XF     = STEP_W'(T_XF - 1);

  seq_st_t           nst;
  logic [STEP_W-1:0] stp, lim;
  logic              fin;

  always_comb begin
    case (st)
      S_VA, S_VB, S_VC, S_VD: lim = D_V;
      S_RG:                   lim = D_RG;
      S_SET:                  lim = D_SET;
      S_XF:                   lim = D_XF;
      default:                lim = '0;
    endcase
  end

  assign fin = (stp == lim);

  always_comb begin
    nst = st;
    case (st)
      S_IDLE:  if (start)   nst = S_INTEG;
      S_INTEG: if (int_end) nst = S_VA;
      S_VA:    if (fin)     nst = S_VB;
      S_VB:    if (fin)     nst = S_VC;
      S_VC:    if (fin)     nst = S_VD;
      S_VD:    if (fin)     nst = S_RG;
      S_RG:    if (fin)     nst = S_SET;
      S_SET:   if (fin)     nst = S_SHP;
      S_SHP:                nst = S_XF;
      S_XF:    if (fin)     nst = S_SHD;
      S_SHD: begin
        if (col != COL_LAST)      nst = S_RG;
        else if (row != ROW_LAST) nst = S_VA;
        else                      nst = S_DONE;
      end
      S_DONE:  nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      stp  <= '0;
      col  <= '0;
      row  <= '0;
      v1   <= 1'b0;
      v2   <= 1'b0;
      h1   <= 1'b1;
      h2   <= 1'b0;
      rg   <= 1'b0;
      shp  <= 1'b0;
      shd  <= 1'b0;
      expo <= 1'b0;
      done <= 1'b0;
    end else begin
      st  <= nst;
      stp <= (nst != st) ? '0 : stp + 1'b1;
      if (st == S_SHD) begin
        if (col == COL_LAST) begin
          col <= '0;
          row <= (row == ROW_LAST) ? '0 : row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
      // outputs follow the next state so they line up with st
      v1   <= (nst == S_VA) || (nst == S_VB);
      v2   <= (nst == S_VB) || (nst == S_VC);
      h2   <= (nst == S_RG) || (nst == S_SET) || (nst == S_SHP);
      h1   <= (nst == S_IDLE) || (nst == S_INTEG) || (nst == S_VA) ||
              (nst == S_VB) || (nst == S_VC) || (nst == S_VD) ||
              (nst == S_XF) || (nst == S_SHD) || (nst == S_DONE);
      rg   <= (nst == S_RG);
      shp  <= (nst == S_SHP);
      shd  <= (nst == S_SHD);
      expo <= (nst == S_INTEG);
      done <= (nst == S_DONE);
    end
  end

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int ACT_COLS   = 64,
  parameter int ACT_ROWS   = 48,
  parameter int LEAD_DUM   = 10,
  parameter int LEAD_DARK  = 4,
  parameter int TRAIL_DARK = 12,
  parameter int TRAIL_DUM  = 2,
  parameter int TOP_ROWS   = 4,
  parameter int BOT_ROWS   = 4,
  parameter int INT_W      = 16,
  parameter int T_V        = 4,
  parameter int T_RG       = 2,
  parameter int T_SET      = 2,
  parameter int T_XF       = 2,
  parameter int STEP_W     = 8,
  localparam int LINE_PIX  = LEAD_DUM + LEAD_DARK + ACT_COLS + TRAIL_DARK + TRAIL_DUM,
  localparam int ROWS      = TOP_ROWS + ACT_ROWS + BOT_ROWS,
  localparam int COL_W     = $clog2(LINE_PIX),
  localparam int ROW_W     = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expose_start,
  input  logic             expose_done,
  input  logic [INT_W-1:0] int_time,
  output logic             vphase1,
  output logic             vphase2,
  output logic             hphase1,
  output logic             hphase2,
  output logic             rst_gate,
  output logic             samp_ref,
  output logic             samp_sig,
  output logic             exposing,
  output logic             frame_done,
  output logic [COL_W-1:0] pix_col,
  output logic [ROW_W-1:0] pix_row,
  output logic [1:0]       pix_kind
);

  seq_st_t   st;
  logic      int_end;
  pix_kind_t kind;

  ccd_int_timer #(.INT_W(INT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (st == S_IDLE),
    .run      (st == S_INTEG),
    .len      (int_time),
    .stop_req (expose_done),
    .expired  (int_end)
  );

  ccd_seq_core #(
    .LINE_PIX (LINE_PIX), .ROWS (ROWS), .T_V (T_V), .T_RG (T_RG),
    .T_SET (T_SET), .T_XF (T_XF), .STEP_W (STEP_W),
    .COL_W (COL_W), .ROW_W (ROW_W)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .start   (expose_start),
    .int_end (int_end),
    .st      (st),
    .col     (pix_col),
    .row     (pix_row),
    .v1      (vphase1),
    .v2      (vphase2),
    .h1      (hphase1),
    .h2      (hphase2),
    .rg      (rst_gate),
    .shp     (samp_ref),
    .shd     (samp_sig),
    .expo    (exposing),
    .done    (frame_done)
  );

  ccd_pix_class #(
    .ACT_COLS (ACT_COLS), .ACT_ROWS (ACT_ROWS), .LEAD_DUM (LEAD_DUM),
    .LEAD_DARK (LEAD_DARK), .TRAIL_DARK (TRAIL_DARK),
    .TOP_ROWS (TOP_ROWS), .BOT_ROWS (BOT_ROWS),
    .COL_W (COL_W), .ROW_W (ROW_W)
  ) u_class (
    .col  (pix_col),
    .row  (pix_row),
    .kind (kind)
  );

  assign pix_kind = kind;

endmodule

// File: rtl/ccd_readout_seq_chk.sv
module ccd_readout_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       vphase1,
  input logic       vphase2,
  input logic       hphase1,
  input logic       hphase2,
  input logic       rst_gate,
  input logic       samp_ref,
  input logic       samp_sig,
  input logic       exposing,
  input logic       frame_done,
  input logic [1:0] pix_kind
);

  a_r2_vert_low_expose: assert property (@(posedge clk) disable iff (rst)
    exposing |-> (!vphase1 && !vphase2));

  a_r3_transfer_after_expose: assert property (@(posedge clk) disable iff (rst)
    $fell(exposing) |-> (vphase1 && !vphase2));

  a_r4_h_hold_during_vert: assert property (@(posedge clk) disable iff (rst)
    (vphase1 || vphase2) |-> (hphase1 && !hphase2));

  a_r4_v2_fall_h1_high: assert property (@(posedge clk) disable iff (rst)
    $fell(vphase2) |-> hphase1);

  a_r5_h_complementary: assert property (@(posedge clk) disable iff (rst)
    hphase1 != hphase2);

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_gate, samp_ref, samp_sig}));

  a_r6_ref_before_h2_fall: assert property (@(posedge clk) disable iff (rst)
    samp_ref |-> hphase2);

  a_r6_sig_after_h2_fall: assert property (@(posedge clk) disable iff (rst)
    samp_sig |-> (!hphase2 && !vphase1 && !vphase2));

  a_r8_kind_legal: assert property (@(posedge clk) disable iff (rst)
    pix_kind != 2'd3);

  a_r10_done_then_idle: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (!frame_done && hphase1 && !hphase2 && !vphase1 &&
                    !vphase2 && !rst_gate && !exposing));

endmodule

bind ccd_readout_seq ccd_readout_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .vphase1    (vphase1),
  .vphase2    (vphase2),
  .hphase1    (hphase1),
  .hphase2    (hphase2),
  .rst_gate   (rst_gate),
  .samp_ref   (samp_ref),
  .samp_sig   (samp_sig),
  .exposing   (exposing),
  .frame_done (frame_done),
  .pix_kind   (pix_kind)
);

// File: tb/sim_ccd_readout_seq.sv
module sim_ccd_readout_seq;

  localparam int AC    = 3;
  localparam int AR    = 2;
  localparam int TV    = 2;
  localparam int TRG   = 1;
  localparam int TSET  = 2;
  localparam int TXF   = 2;
  localparam int IW    = 8;
  localparam int LP    = AC + 28;
  localparam int NR    = AR + 8;
  localparam int PIX   = TRG + TSET + TXF + 2;
  localparam int LINE  = 4*TV + LP*PIX;
  localparam int FRAME = NR*LINE;
  localparam int CW    = $clog2(LP);
  localparam int RW    = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          expose_start = 1'b0;
  logic          expose_done = 1'b0;
  logic [IW-1:0] int_time = '0;
  logic          vphase1, vphase2, hphase1, hphase2;
  logic          rst_gate, samp_ref, samp_sig, exposing, frame_done;
  logic [CW-1:0] pix_col;
  logic [RW-1:0] pix_row;
  logic [1:0]    pix_kind;

  always #10 clk = ~clk;

  ccd_readout_seq #(
    .ACT_COLS (AC), .ACT_ROWS (AR), .INT_W (IW), .T_V (TV),
    .T_RG (TRG), .T_SET (TSET), .T_XF (TXF)
  ) u0 (
    .clk (clk), .rst (rst), .expose_start (expose_start),
    .expose_done (expose_done), .int_time (int_time),
    .vphase1 (vphase1), .vphase2 (vphase2), .hphase1 (hphase1),
    .hphase2 (hphase2), .rst_gate (rst_gate), .samp_ref (samp_ref),
    .samp_sig (samp_sig), .exposing (exposing), .frame_done (frame_done),
    .pix_col (pix_col), .pix_row (pix_row), .pix_kind (pix_kind)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_kind(input int c, input int r);
    if (c < 10 || c >= LP - 2) return 0;
    if (c < 14 || c >= 14 + AC || r < 4 || r >= 4 + AR) return 1;
    return 2;
  endfunction

  // monitor state
  int cyc = 0, exp_first = 0, n_exp = 0, exp_cnt = 0, exp_want = 0;
  int v1_rise = 0, v2f = 0, h2f_row = 0, shd_row = 0;
  int rg_rise = 0, shp_cyc = 0, h2f_cyc = 0;
  bit v_in_exp = 0, compl_bad = 0;
  logic p_exp = 0, p_v1 = 0, p_v2 = 0, p_h2 = 0, p_rg = 0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (exposing && !p_exp) begin exp_first = cyc; exp_cnt++; n_exp = 0; end
      if (exposing) begin
        n_exp++;
        if (vphase1 || vphase2) v_in_exp = 1;
      end
      if (!exposing && p_exp) begin
        chk(n_exp == exp_want, "R2 exposure length", n_exp, exp_want);
        chk(!v_in_exp, "R2 vertical low while exposing", int'(v_in_exp), 0);
        chk(vphase1 && !vphase2, "R3 transfer right after exposure",
            int'({vphase1, vphase2}), 2);
        v_in_exp = 0;
      end
      if (vphase1 && !p_v1) v1_rise = cyc;
      if (!vphase2 && p_v2) begin
        chk(cyc - v1_rise == 3*TV, "R4 V2 fall after V1 rise", cyc - v1_rise, 3*TV);
        chk(hphase1 && !hphase2, "R4 H1 high at line load",
            int'({hphase1, hphase2}), 2);
        if (v2f > 0) chk(h2f_row == LP, "R5 shifts per row", h2f_row, LP);
        v2f++;
        h2f_row = 0;
        shd_row = 0;
      end
      if (!hphase2 && p_h2) begin h2f_row++; h2f_cyc = cyc; end
      if (rst_gate && !p_rg) rg_rise = cyc;
      if (!rst_gate && p_rg)
        chk(cyc - rg_rise == TRG, "R6 reset pulse width", cyc - rg_rise, TRG);
      if (samp_ref) shp_cyc = cyc;
      if (samp_sig) begin
        chk(cyc - rg_rise == PIX - 1, "R6 reset to signal sample", cyc - rg_rise, PIX - 1);
        chk(cyc - shp_cyc == TXF + 1, "R6 ref to signal sample", cyc - shp_cyc, TXF + 1);
        chk(cyc - h2f_cyc == TXF, "R6 H2 fall to signal sample", cyc - h2f_cyc, TXF);
        chk(int'(pix_col) == shd_row, "R7 column tag", int'(pix_col), shd_row);
        chk(int'(pix_row) == v2f - 1, "R7 row tag", int'(pix_row), v2f - 1);
        if (v2f - 1 < 4 || v2f - 1 >= 4 + AR)
          chk(int'(pix_kind) == exp_kind(shd_row, v2f - 1), "R9 dark row kind",
              int'(pix_kind), exp_kind(shd_row, v2f - 1));
        else
          chk(int'(pix_kind) == exp_kind(shd_row, v2f - 1), "R8 column kind",
              int'(pix_kind), exp_kind(shd_row, v2f - 1));
        shd_row++;
      end
      if (hphase1 == hphase2) compl_bad = 1;
      if (frame_done) begin
        chk(cyc - exp_first == n_exp + FRAME, "R10 frame length",
            cyc - exp_first, n_exp + FRAME);
        chk(v2f == NR, "R4 line transfers per frame", v2f, NR);
        chk(h2f_row == LP, "R5 shifts in last row", h2f_row, LP);
        chk(!compl_bad, "R5 H phases complementary", int'(compl_bad), 0);
        compl_bad = 0;
        v2f = 0;
        h2f_row = 0;
      end
      p_exp = exposing; p_v1 = vphase1; p_v2 = vphase2;
      p_h2  = hphase2;  p_rg = rst_gate;
    end
  end

  task automatic check_idle(input string req);
    chk(!vphase1 && !vphase2 && hphase1 && !hphase2 && !rst_gate && !samp_ref &&
        !samp_sig && !exposing && !frame_done, req,
        int'({vphase1, vphase2, hphase1, hphase2, rst_gate, samp_ref,
              samp_sig, exposing, frame_done}), 9'b001000000);
  endtask

  task automatic run_frame(input int len, input int early, input int want, input bit stray);
    exp_want = want;
    int_time = IW'(len);
    @(negedge clk) expose_start = 1'b1;
    @(negedge clk) expose_start = 1'b0;
    if (early > 0) begin
      repeat (early - 1) @(negedge clk);
      expose_done = 1'b1;
      @(negedge clk) expose_done = 1'b0;
    end
    if (stray) begin
      while (!vphase1) @(negedge clk);
      repeat (100) @(negedge clk);
      expose_start = 1'b1;
      @(negedge clk) expose_start = 1'b0;
    end
    while (!frame_done) @(negedge clk);
    @(negedge clk);
    check_idle("R10 idle after frame done");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check_idle("R1 reset levels");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 idle before start");
    run_frame(5, 0, 5, 1'b0);
    run_frame(1, 0, 1, 1'b0);
    run_frame(0, 0, 1, 1'b0);
    run_frame(200, 7, 7, 1'b0);
    run_frame(4, 0, 4, 1'b1);
    repeat (30) @(negedge clk);
    chk(exp_cnt == 5, "R11 stray start ignored", exp_cnt, 5);
    check_idle("R11 still idle after stray start");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule